// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins (64 by default). Every pin owns one 32-bit configuration word. That word holds the driven data bit, a 3-bit mode that selects either output drive or one of several interrupt behaviours, a stored peripheral-function select, pull and input-enable bits, and a 3-bit interrupt-group selector. Bits that describe pad electronics are kept only so that software can read them back.

Each pin input passes through a two-flop synchronizer and then into an event detector that the pin's mode sets. A detected event sets a sticky pending bit in the group that the pin selects. Software clears pending bits by writing ones. Each group drives one interrupt line, which is high while any pending bit of a pin that currently selects that group is set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The configuration word of pin n is at byte address 4*n. A write stores all 32 bits. A read request returns data on bus_rdata, with bus_rvalid high, in the cycle after the request, and every bit except bit 0 reads back as written.
- R2: Bit 0 of a configuration read returns the stored data bit when the mode field (bits 3:1) equals 1. For any other mode it returns the synchronized level of the pin.
- R3: pin_out always equals bit 0 of the pin's word. pin_oe is high only when the mode is 1 and the function select (bits 6:5) is 0.
- R4: Mode 2 raises an event on every clock while the synchronized pin is high, and mode 3 does so while it is low. A clear written while the level still holds is overridden in the same cycle, so the pending bit stays set.
- R5: Mode 4 raises an event on a rising edge, mode 5 on a falling edge and mode 6 on either edge, each detected after the two-flop synchronizer. A change on pin_in is visible on irq_out after the third rising clock edge.
- R6: Modes 0, 1 and 7 raise no events. Writing a trigger mode back re-enables events for later input changes.
- R7: The pending word of group g that covers pins 32*w to 32*w+31 is at byte address 0x800 + 0x40*g + 4*w, and pin p sits at bit p mod 32. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: An event sets the pending bit only in the group named by bits 18:16. irq_out[g] is the OR of the group-g pending bits of pins whose group field currently equals g. A pending bit left behind after a pin moves to another group stays readable but no longer drives irq_out[g].
- R9: A read of an unmapped or unaligned address returns 0, and a write to one changes no register. Unmapped addresses are pin indices at or above NUM_PINS, groups at or above NUM_GROUPS, words at or above the word count, and any address with bits 1:0 nonzero.
- R10: After reset every configuration word is 0, no bit is pending, and pin_oe and irq_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High in the cycle after a read request |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Driven data per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq_out | output | NUM_GROUPS | One interrupt line per group |

## Verification
The bench clears a level-triggered pending bit while the level still holds. A design in which the clear beats the set would drop the interrupt for one cycle and then report a bit that software had just cleared. It moves a pin with a pending bit to another group. A design that routed the output through the bit's storage instead of the pin's current group would keep the old line high. It drives edges of the wrong polarity and toggles pins that are masked, both of which must leave the lines low. It writes zero to pending words and sends writes to unmapped addresses whose truncated index would alias a real register, so a decoder that drops upper address bits would corrupt a live pin or clear a live pending bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    MD_NONE   = 3'd0,
    MD_DRIVE  = 3'd1,
    MD_LVL_HI = 3'd2,
    MD_LVL_LO = 3'd3,
    MD_RISE   = 3'd4,
    MD_FALL   = 3'd5,
    MD_BOTH   = 3'd6,
    MD_QUIET  = 3'd7
  } pin_mode_e;

  localparam int DATA_BIT  = 0;
  localparam int MODE_LSB  = 1;
  localparam int FUNC_LSB  = 5;
  localparam int GRP_LSB   = 16;
  localparam int WORD_BITS = 32;

endpackage

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pad_in,
  input  pin_mode_e mode,
  output logic      level_sync,
  output logic      event_o
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    case (mode)
      MD_LVL_HI: event_o = sync_q;
      MD_LVL_LO: event_o = ~sync_q;
      MD_RISE:   event_o = sync_q & ~prev_q;
      MD_FALL:   event_o = ~sync_q & prev_q;
      MD_BOTH:   event_o = sync_q ^ prev_q;
      default:   event_o = 1'b0;
    endcase
  end

  assign level_sync = sync_q;

  // R5: a rising-edge event only when the synchronized level just went high
  p_rise_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RISE && event_o) |-> (level_sync && !$past(level_sync)));

  // R5: a falling-edge event only when the synchronized level just went low
  p_fall_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FALL && event_o) |-> (!level_sync && $past(level_sync)));

endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  input  logic [NUM_PINS-1:0] route_vec,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic                upd_en;

  // set wins over a same-cycle clear
  always_comb begin
    pend_d = (pend_q & ~clr_vec) | set_vec;
    upd_en = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & route_vec);

  // R4: every event lands in the next cycle even against a clear
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R7: a written one without a concurrent event clears the bit
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  // R7: with no event and no clear the pending state holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(pend_q));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_GROUPS-1:0] irq_out
);

  localparam int WORDS = (NUM_PINS + WORD_BITS - 1) / WORD_BITS;
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int WRD_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic cfg_wr, pend_wr, rd_en, rd_hit;
  logic [NUM_PINS-1:0][31:0]                 rd_view;
  logic [NUM_PINS-1:0][2:0]                  grp_all;
  logic [NUM_PINS-1:0]                       evt_all;
  logic [NUM_GROUPS-1:0][NUM_PINS-1:0]       pend_mat;
  logic [NUM_GROUPS-1:0][WORDS-1:0][31:0]    pend_words;
  logic [31:0] rdata_d, rdata_q;
  logic        rvalid_q;

  assign cfg_wr  = bus_req && bus_we && !bus_addr[11] && (bus_addr[1:0] == 2'b00);
  assign pend_wr = bus_req && bus_we &&  bus_addr[11] && (bus_addr[1:0] == 2'b00);
  assign rd_en   = bus_req && !bus_we;

  // per-pin configuration storage and event detection
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [31:0] cfg_q, cfg_d;
    logic        wr_hit, sync_v, evt_v;
    pin_mode_e   md;

    assign wr_hit = cfg_wr && (bus_addr[10:2] == 9'(i));

    always_comb begin
      cfg_d = cfg_q;
      if (wr_hit) cfg_d = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_hit) cfg_q <= cfg_d;
    end

    assign md = pin_mode_e'(cfg_q[MODE_LSB +: 3]);

    gpio_pin_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .pad_in     (pin_in[i]),
      .mode       (md),
      .level_sync (sync_v),
      .event_o    (evt_v)
    );

    assign pin_out[i] = cfg_q[DATA_BIT];
    assign pin_oe[i]  = (md == MD_DRIVE) && (cfg_q[FUNC_LSB +: 2] == 2'b00);
    assign rd_view[i] = {cfg_q[31:1], (md == MD_DRIVE) ? cfg_q[DATA_BIT] : sync_v};
    assign grp_all[i] = cfg_q[GRP_LSB +: 3];
    assign evt_all[i] = evt_v;
  end

  // per-group pending banks
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [NUM_PINS-1:0] set_v, clr_v, route_v;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      assign route_v[i] = (grp_all[i] == 3'(g));
      assign set_v[i]   = evt_all[i] && route_v[i];
      assign clr_v[i]   = pend_wr && (bus_addr[10:6] == 5'(g)) &&
                          (bus_addr[5:2] == 4'(i / WORD_BITS)) &&
                          bus_wdata[i % WORD_BITS];
    end

    gpio_pend_bank #(.NUM_PINS(NUM_PINS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_v),
      .clr_vec   (clr_v),
      .route_vec (route_v),
      .pend_o    (pend_mat[g]),
      .irq_o     (irq_out[g])
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < WORD_BITS; b++) begin : g_wbit
        if (w * WORD_BITS + b < NUM_PINS) begin : g_live
          assign pend_words[g][w][b] = pend_mat[g][w * WORD_BITS + b];
        end else begin : g_pad
          assign pend_words[g][w][b] = 1'b0;
        end
      end
    end
  end

  // read decode
  always_comb begin
    rd_hit  = 1'b0;
    rdata_d = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (!bus_addr[11]) begin
        if (int'(bus_addr[10:2]) < NUM_PINS) begin
          rd_hit  = 1'b1;
          rdata_d = rd_view[bus_addr[PIN_W+1:2]];
        end
      end else if (int'(bus_addr[10:6]) < NUM_GROUPS && int'(bus_addr[5:2]) < WORDS) begin
        rd_hit  = 1'b1;
        rdata_d = pend_words[bus_addr[GRP_W+5:6]][bus_addr[WRD_W+1:2]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R1: read data is valid exactly one cycle after a read request
  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));

  // R9: a read that hit no register returns zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && !$past(rd_hit)) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int NG = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NG-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // driver: push expected value, then issue the read
  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_irq(logic [NG-1:0] e, string tag);
    chk(irq_out == e, tag, irq_out, e);
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 read data with nothing expected", bus_rdata, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk_irq('0, "R10 irq after reset");
    chk(pin_oe == '0, "R10 pin_oe after reset", pin_oe, 0);
    rd(12'h00C, 32'h0, "R10 config word after reset");
    rd(12'h800, 32'h0, "R10 pending after reset");

    // R1 full-word store, R3 function select blocks drive
    wr(12'h00C, 32'h00A3_8BF2);
    rd(12'h00C, 32'h00A3_8BF2, "R1 readback pin 3");
    chk(pin_oe[3] == 1'b0, "R3 oe off with function select 3", pin_oe[3], 0);
    wr(12'h00C, 32'h0000_0003);
    chk(pin_oe[3] == 1'b1, "R3 oe on in drive mode", pin_oe[3], 1);
    chk(pin_out[3] == 1'b1, "R3 pin_out follows data", pin_out[3], 1);
    rd(12'h00C, 32'h3, "R2 drive mode reads driven data");
    wr(12'h00C, 32'h0000_0023);
    chk(pin_oe[3] == 1'b0, "R3 oe off with function select 1", pin_oe[3], 0);
    chk(pin_out[3] == 1'b1, "R3 pin_out still data", pin_out[3], 1);

    // R2 live input
    wr(12'h028, 32'hE);
    pin_in[10] = 1'b1; settle();
    rd(12'h028, 32'hF, "R2 live input high");
    pin_in[10] = 1'b0; settle();
    rd(12'h028, 32'hE, "R2 live input low");

    // R5 rising edge, pin 40 group 2, R7 zero write and W1C
    wr(12'h0A0, 32'h0002_0008);
    pin_in[40] = 1'b1;
    repeat (3) @(negedge clk);
    chk_irq(8'h04, "R5 rise visible after three edges");
    rd(12'h884, 32'h100, "R7 pending bit position pin 40");
    wr(12'h884, 32'h0);
    rd(12'h884, 32'h100, "R7 writing zero keeps pending");
    wr(12'h884, 32'h100);
    chk_irq(8'h00, "R7 write one clears");
    pin_in[40] = 1'b0; settle();
    chk_irq(8'h00, "R5 rise mode ignores fall");

    // R5 falling edge
    wr(12'h0A0, 32'h0002_000A);
    pin_in[40] = 1'b1; settle();
    chk_irq(8'h00, "R5 fall mode ignores rise");
    pin_in[40] = 1'b0; settle();
    chk_irq(8'h04, "R5 fall detected");
    wr(12'h884, 32'h100);

    // R5 both edges
    wr(12'h0A0, 32'h0002_000C);
    pin_in[40] = 1'b1; settle();
    chk_irq(8'h04, "R5 both mode rise");
    wr(12'h884, 32'h100);
    pin_in[40] = 1'b0; settle();
    chk_irq(8'h04, "R5 both mode fall");
    wr(12'h884, 32'h100);
    chk_irq(8'h00, "R5 both mode cleared");

    // R4 level high, pin 7 group 0
    wr(12'h01C, 32'h4);
    pin_in[7] = 1'b1; settle();
    chk_irq(8'h01, "R4 level high sets");
    wr(12'h800, 32'h80);
    chk_irq(8'h01, "R4 clear overridden while level holds");
    rd(12'h800, 32'h80, "R4 pending reasserted");
    pin_in[7] = 1'b0; settle();
    wr(12'h800, 32'h80);
    chk_irq(8'h00, "R4 clear sticks after level drops");

    // R4 level low, pin 8 group 5
    wr(12'h020, 32'h0005_0006);
    settle();
    chk_irq(8'h20, "R4 level low sets group 5");
    rd(12'h940, 32'h100, "R7 group 5 pending address");
    pin_in[8] = 1'b1; settle();
    wr(12'h940, 32'h100);
    chk_irq(8'h00, "R4 level low released");

    // R6 masking
    wr(12'h0A0, 32'h0002_000E);
    pin_in[40] = 1'b1; settle();
    pin_in[40] = 1'b0; settle();
    chk_irq(8'h00, "R6 mode 7 raises nothing");
    rd(12'h884, 32'h0, "R6 no pending in mode 7");
    wr(12'h0A0, 32'h0002_0000);
    pin_in[40] = 1'b1; settle();
    chk_irq(8'h00, "R6 mode 0 raises nothing");
    wr(12'h0A0, 32'h0002_0008);
    pin_in[40] = 1'b0; settle();
    chk_irq(8'h00, "R6 unmasked rise mode ignores fall");
    pin_in[40] = 1'b1; settle();
    chk_irq(8'h04, "R6 unmask re-enables events");

    // R8 group routing
    wr(12'h0A0, 32'h0003_0008);
    chk_irq(8'h00, "R8 old group line drops after move");
    rd(12'h884, 32'h100, "R8 stale pending still readable");
    rd(12'h8C4, 32'h0, "R8 new group empty before event");
    pin_in[40] = 1'b0; settle();
    pin_in[40] = 1'b1; settle();
    chk_irq(8'h08, "R8 event lands in new group");
    rd(12'h8C4, 32'h100, "R8 new group pending");
    wr(12'h884, 32'h100);

    // R9 unmapped accesses
    wr(12'h8CC, 32'hFFFF_FFFF);
    chk_irq(8'h08, "R9 write to missing word clears nothing");
    wr(12'h8C6, 32'hFFFF_FFFF);
    chk_irq(8'h08, "R9 unaligned write clears nothing");
    wr(12'h000, 32'h600);
    wr(12'h400, 32'h1234_5678);
    rd(12'h000, 32'h600, "R9 unmapped write leaves pin 0");
    rd(12'h400, 32'h0, "R9 pin index beyond range reads 0");
    rd(12'h8CC, 32'h0, "R9 missing word reads 0");
    rd(12'hC00, 32'h0, "R9 missing group reads 0");
    rd(12'h002, 32'h0, "R9 unaligned read 0");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all reads answered", exp_q.size(), 0);
    finish_run();
  end

endmodule